// File: doc/BRIEF.md
# Strip-Sensor Analog Pipeline Readout Sequencer

This block produces the digital control lines for a multi-channel analog front-end chip in which every channel keeps a short history of its input on a ring of storage capacitors. In the sampling phase it keeps a single select bit circling through the storage ring, one slot per clock, with both the sample-mode and the input-select controls held high. A trigger freezes the ring, moves the select bit back by a programmable trigger delay to the slot that holds the event of interest, and drops both controls so that slot feeds the amplifier again.

The block then walks a one-hot channel-select bit across every channel, one channel per clock, and raises an ADC sample strobe one clock after each step so the analog output can settle. After the last channel it pulses `done`, reloads the select bit at slot 0 and goes back to sampling. Triggers that land during readout are dropped and counted. Around this it times a channel-clear pulse to a beam-crossing input and, when enabled, a calibration-injection edge at a chosen ring position. A static leakage-bleed enable passes straight through untouched.

Top module: `strip_pipe_seq`

## Requirements
- R1: Out of reset the block is sampling: `sample_ctl` and `insel_ctl` are both 1, `pipe_sel` is 1 (slot 0), `chan_sel` is 0 and `adc_strobe`, `done`, `reset_ctl` and `dropped_cnt` are 0.
- R2: While sampling with no trigger, the single set bit of `pipe_sel` moves from bit i to bit i+1 on each clock, and from bit 31 back to bit 0.
- R3: A trigger sampled high while sampling makes `sample_ctl` and `insel_ctl` both 0 from the next cycle on, and the ring stops advancing.
- R4: The slot shown on `pipe_sel` during readout is (s - `trig_delay`) mod 32, where s is the slot shown in the cycle the trigger was sampled.
- R5: Readout lasts 128 cycles; in readout cycle k (k = 0 is the first cycle after the trigger edge) `chan_sel` has only bit k set; outside readout `chan_sel` is 0.
- R6: `adc_strobe` is 1 in the cycle after each readout cycle, with `adc_chan` equal to that cycle's channel number k.
- R7: In the cycle after channel 127, `done` is 1 for one cycle, the block is sampling again, `pipe_sel` is 1 and `chan_sel` is 0.
- R8: A trigger during readout does not change the readout sequence and raises `dropped_cnt` by one, holding at 255.
- R9: `reset_ctl` is 1 in the cycle after `beam_xing` is sampled high while sampling without a trigger, and is never 1 during readout.
- R10: With `cal_enable` at 1, `cal_ctl` is 1 until the ring shows `cal_slot` while sampling, falls to 0 in the next cycle, stays 0 until `done`, and is 1 again in the `done` cycle; with `cal_enable` at 0, `cal_ctl` is 0.
- R11: `bleed_ctl` follows `bleed_en` in every phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, one ring slot or one channel per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| trigger | input | 1 | Event trigger, sampled each clock |
| beam_xing | input | 1 | Beam-crossing marker for the channel-clear pulse |
| trig_delay | input | 5 | Slots to rewind from the current slot on a trigger |
| cal_enable | input | 1 | Enables calibration-charge injection |
| cal_slot | input | 5 | Ring slot after which the calibration line falls |
| bleed_en | input | 1 | Static leakage-bleed enable |
| sample_ctl | output | 1 | Sample-mode control, 1 while sampling |
| insel_ctl | output | 1 | Input-select control, 1 while sampling |
| pipe_sel | output | 32 | One-hot storage-slot select |
| chan_sel | output | 128 | One-hot readout channel select |
| adc_strobe | output | 1 | ADC sample strobe, one cycle after each readout step |
| adc_chan | output | 7 | Channel number belonging to the current strobe |
| done | output | 1 | One-cycle pulse at the end of a readout |
| reset_ctl | output | 1 | Channel-clear pulse |
| cal_ctl | output | 1 | Calibration injection line |
| bleed_ctl | output | 1 | Leakage-bleed control |
| dropped_cnt | output | 8 | Saturating count of triggers ignored during readout |

## Verification
The hardest state to reach from the ports is a saturated dropped-trigger counter, since each readout can drop at most 128 triggers and every trigger seen while sampling starts a new readout instead of being counted. The bench holds the trigger high across more than two back-to-back readouts so the count passes 255, then checks it stays there. The rewind across the slot-31/slot-0 boundary is reached by watching `pipe_sel` until slot 2 appears and triggering there with a delay of 5.

// File: rtl/stripseq_pkg.sv
`timescale 1ns/1ps
// Package: shared phase type of the readout sequencer.
// Assumes: two phases are enough; finishing a readout goes straight back to sampling.
package stripseq_pkg;
    typedef enum logic {
        PH_SAMPLE = 1'b0,
        PH_READ   = 1'b1
    } seq_phase_e;
endpackage

// File: rtl/stripseq_slot_ring.sv
`timescale 1ns/1ps
// Module: stripseq_slot_ring
// Holds the index of the storage slot currently selected and decodes it
// into a one-hot select. Advances while sampling, rewinds by the trigger
// delay on an accepted trigger and reloads slot 0 at the end of a readout.
// Assumes: N_SLOTS is a power of two, so index arithmetic wraps for free.
module stripseq_slot_ring #(
    parameter int N_SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       advance,
    input  logic                       rewind,
    input  logic                       reload,
    input  logic [$clog2(N_SLOTS)-1:0] delay,
    output logic [$clog2(N_SLOTS)-1:0] slot,
    output logic [N_SLOTS-1:0]         sel
);
    localparam int SW = $clog2(N_SLOTS);

    // Slot index update: reload wins, then rewind, then plain advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (reload) begin
            slot <= '0;
        end else if (rewind) begin
            slot <= slot - delay;
        end else if (advance) begin
            slot <= slot + 1'b1;
        end
    end

    // One-hot decode of the slot index, one comparator per slot.
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_sel
        assign sel[g] = (slot == SW'(g));
    end
endmodule

// File: rtl/stripseq_chan_scan.sv
`timescale 1ns/1ps
// Module: stripseq_chan_scan
// Walks a channel index across all channels while active, decodes it to a
// one-hot channel select and produces a delayed ADC strobe with the channel
// number of the step it belongs to.
// Assumes: start coincides with the cycle before the first active cycle.
module stripseq_chan_scan #(
    parameter int N_CHAN = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      active,
    output logic                      last,
    output logic [N_CHAN-1:0]         sel,
    output logic                      strobe,
    output logic [$clog2(N_CHAN)-1:0] strobe_chan
);
    localparam int CW = $clog2(N_CHAN);

    logic [CW-1:0] idx;

    // Channel index: cleared on start, stepped once per active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (start) begin
            idx <= '0;
        end else if (active) begin
            idx <= idx + 1'b1;
        end
    end

    // Strobe one cycle behind each step, carrying that step's channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe      <= 1'b0;
            strobe_chan <= '0;
        end else begin
            strobe      <= active;
            strobe_chan <= idx;
        end
    end

    assign last = active && (idx == CW'(N_CHAN - 1));

    // One-hot channel select, gated off outside the scan.
    for (genvar g = 0; g < N_CHAN; g++) begin : g_sel
        assign sel[g] = active && (idx == CW'(g));
    end
endmodule

// File: rtl/stripseq_ctrl.sv
`timescale 1ns/1ps
// Module: stripseq_ctrl
// Phase controller: accepts triggers while sampling, ends readout after the
// last channel, counts triggers refused during readout, times the channel
// clear pulse and the calibration-injection edge.
// Assumes: scan_last is high for exactly one readout cycle.
module stripseq_ctrl
    import stripseq_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trigger,
    input  logic                       beam_xing,
    input  logic                       cal_enable,
    input  logic [$clog2(N_SLOTS)-1:0] cal_slot,
    input  logic [$clog2(N_SLOTS)-1:0] slot,
    input  logic                       scan_last,
    output logic                       reading,
    output logic                       accept,
    output logic                       finish,
    output logic                       done,
    output logic                       reset_ctl,
    output logic                       cal_ctl,
    output logic [CNT_W-1:0]           dropped
);
    localparam logic [CNT_W-1:0] DROP_MAX = {CNT_W{1'b1}};

    seq_phase_e phase;
    logic       cal_armed;

    assign reading = (phase == PH_READ);
    assign accept  = (phase == PH_SAMPLE) && trigger;
    assign finish  = reading && scan_last;

    // Phase register: sample until a trigger, read until the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_SAMPLE;
        end else if (accept) begin
            phase <= PH_READ;
        end else if (finish) begin
            phase <= PH_SAMPLE;
        end
    end

    // End-of-readout pulse, one cycle after the last channel step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= finish;
        end
    end

    // Saturating count of triggers refused during readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dropped <= '0;
        end else if (reading && trigger && (dropped != DROP_MAX)) begin
            dropped <= dropped + 1'b1;
        end
    end

    // Channel-clear pulse following a beam crossing while sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_ctl <= 1'b0;
        end else begin
            reset_ctl <= beam_xing && (phase == PH_SAMPLE) && !trigger;
        end
    end

    // Calibration arm: drops at the programmed slot, re-arms at readout end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_armed <= 1'b1;
        end else if (finish) begin
            cal_armed <= 1'b1;
        end else if ((phase == PH_SAMPLE) && cal_enable && (slot == cal_slot)) begin
            cal_armed <= 1'b0;
        end
    end

    assign cal_ctl = cal_enable && cal_armed;
endmodule

// File: rtl/strip_pipe_seq.sv
`timescale 1ns/1ps
// Module: strip_pipe_seq (top)
// Readout sequencer for a front-end chip with a ring of analog storage
// slots per channel and a serial channel readout. Joins the slot ring,
// the channel scan and the phase controller.
// Assumes: N_SLOTS and N_CHAN are powers of two; bleed_en is static.
module strip_pipe_seq #(
    parameter int N_SLOTS = 32,
    parameter int N_CHAN  = 128,
    parameter int CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trigger,
    input  logic                       beam_xing,
    input  logic [$clog2(N_SLOTS)-1:0] trig_delay,
    input  logic                       cal_enable,
    input  logic [$clog2(N_SLOTS)-1:0] cal_slot,
    input  logic                       bleed_en,
    output logic                       sample_ctl,
    output logic                       insel_ctl,
    output logic [N_SLOTS-1:0]         pipe_sel,
    output logic [N_CHAN-1:0]          chan_sel,
    output logic                       adc_strobe,
    output logic [$clog2(N_CHAN)-1:0]  adc_chan,
    output logic                       done,
    output logic                       reset_ctl,
    output logic                       cal_ctl,
    output logic                       bleed_ctl,
    output logic [CNT_W-1:0]           dropped_cnt
);
    localparam int SW = $clog2(N_SLOTS);

    logic          reading;
    logic          accept;
    logic          finish;
    logic          scan_last;
    logic [SW-1:0] slot;

    stripseq_ctrl #(
        .N_SLOTS (N_SLOTS),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trigger    (trigger),
        .beam_xing  (beam_xing),
        .cal_enable (cal_enable),
        .cal_slot   (cal_slot),
        .slot       (slot),
        .scan_last  (scan_last),
        .reading    (reading),
        .accept     (accept),
        .finish     (finish),
        .done       (done),
        .reset_ctl  (reset_ctl),
        .cal_ctl    (cal_ctl),
        .dropped    (dropped_cnt)
    );

    stripseq_slot_ring #(
        .N_SLOTS (N_SLOTS)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (!reading && !trigger),
        .rewind  (accept),
        .reload  (finish),
        .delay   (trig_delay),
        .slot    (slot),
        .sel     (pipe_sel)
    );

    stripseq_chan_scan #(
        .N_CHAN (N_CHAN)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .active      (reading),
        .last        (scan_last),
        .sel         (chan_sel),
        .strobe      (adc_strobe),
        .strobe_chan (adc_chan)
    );

    // Mode controls: both high while sampling, both low while reading.
    assign sample_ctl = !reading;
    assign insel_ctl  = !reading;
    assign bleed_ctl  = bleed_en;
endmodule

// File: rtl/stripseq_checker.sv
`timescale 1ns/1ps
// Module: stripseq_checker
// Temporal properties of the sequencer seen at its ports, bound to the top.
module stripseq_checker #(
    parameter int N_SLOTS = 32,
    parameter int N_CHAN  = 128,
    parameter int CNT_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trigger,
    input logic               sample_ctl,
    input logic               insel_ctl,
    input logic [N_SLOTS-1:0] pipe_sel,
    input logic [N_CHAN-1:0]  chan_sel,
    input logic               adc_strobe,
    input logic               done,
    input logic               reset_ctl,
    input logic [CNT_W-1:0]   dropped_cnt
);
    logic [N_SLOTS-1:0] rot;
    assign rot = {pipe_sel[N_SLOTS-2:0], pipe_sel[N_SLOTS-1]};

    p_modes_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ctl == insel_ctl);

    p_slot_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(pipe_sel));

    p_slot_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_ctl && !trigger) |=> (pipe_sel == $past(rot)));

    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_ctl && trigger) |=> (!sample_ctl && !insel_ctl));

    p_chan_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_ctl |-> $onehot(chan_sel));

    p_chan_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ctl |-> (chan_sel == '0));

    p_strobe_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_ctl |=> adc_strobe);

    p_done_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sample_ctl && pipe_sel[0]));

    p_drop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_ctl && trigger && (dropped_cnt != {CNT_W{1'b1}}))
        |=> (dropped_cnt == $past(dropped_cnt) + 1'b1));

    p_no_clear_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_ctl |-> !reset_ctl);
endmodule

bind strip_pipe_seq stripseq_checker #(
    .N_SLOTS (N_SLOTS),
    .N_CHAN  (N_CHAN),
    .CNT_W   (CNT_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .trigger     (trigger),
    .sample_ctl  (sample_ctl),
    .insel_ctl   (insel_ctl),
    .pipe_sel    (pipe_sel),
    .chan_sel    (chan_sel),
    .adc_strobe  (adc_strobe),
    .done        (done),
    .reset_ctl   (reset_ctl),
    .dropped_cnt (dropped_cnt)
);

// File: tb/strip_pipe_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for strip_pipe_seq: one task per scenario.
module strip_pipe_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trigger = 1'b0;
    logic         beam_xing = 1'b0;
    logic [4:0]   trig_delay = 5'd0;
    logic         cal_enable = 1'b0;
    logic [4:0]   cal_slot = 5'd0;
    logic         bleed_en = 1'b0;
    logic         sample_ctl, insel_ctl, adc_strobe, done, reset_ctl, cal_ctl, bleed_ctl;
    logic [31:0]  pipe_sel;
    logic [127:0] chan_sel;
    logic [6:0]   adc_chan;
    logic [7:0]   dropped_cnt;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    strip_pipe_seq u_strip_pipe_seq (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .beam_xing(beam_xing),
        .trig_delay(trig_delay), .cal_enable(cal_enable), .cal_slot(cal_slot),
        .bleed_en(bleed_en), .sample_ctl(sample_ctl), .insel_ctl(insel_ctl),
        .pipe_sel(pipe_sel), .chan_sel(chan_sel), .adc_strobe(adc_strobe),
        .adc_chan(adc_chan), .done(done), .reset_ctl(reset_ctl), .cal_ctl(cal_ctl),
        .bleed_ctl(bleed_ctl), .dropped_cnt(dropped_cnt)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_slot(input int s);
        for (int i = 0; i < 40; i++) begin
            if (slot_of(pipe_sel) == s) return;
            @(negedge clk);
        end
    endtask

    task automatic wait_sampling();
        for (int i = 0; i < 300; i++) begin
            if (sample_ctl) return;
            @(negedge clk);
        end
    endtask

    // Trigger at the current negedge, check the whole readout; n_extra
    // triggers are raised during readout starting at step 10.
    task automatic run_read(input logic [4:0] d, input int n_extra);
        int s;
        logic [7:0] cnt0;
        trig_delay = d;
        s = slot_of(pipe_sel);
        cnt0 = dropped_cnt;
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk("R3 sample_ctl low after trigger", 128'(sample_ctl), 128'd0);
        chk("R3 insel_ctl low after trigger", 128'(insel_ctl), 128'd0);
        chk("R4 rewound slot", 128'(pipe_sel), 128'(32'd1 << ((s - d) & 31)));
        for (int k = 0; k < 128; k++) begin
            chk("R5 channel select", chan_sel, 128'd1 << k);
            chk("R6 strobe", 128'(adc_strobe), 128'(k > 0));
            if (k > 0) chk("R6 strobe channel", 128'(adc_chan), 128'(k - 1));
            if (k == 64) chk("R3 ring frozen", 128'(pipe_sel), 128'(32'd1 << ((s - d) & 31)));
            trigger = (k >= 10) && (k < 10 + n_extra);
            @(negedge clk);
        end
        trigger = 1'b0;
        chk("R7 done pulse", 128'(done), 128'd1);
        chk("R7 back to sampling", 128'(sample_ctl), 128'd1);
        chk("R7 slot reloaded", 128'(pipe_sel), 128'd1);
        chk("R7 channel select idle", chan_sel, 128'd0);
        chk("R6 last strobe", 128'(adc_strobe), 128'd1);
        chk("R6 last strobe channel", 128'(adc_chan), 128'd127);
        chk("R8 dropped count", 128'(dropped_cnt),
            128'((int'(cnt0) + n_extra > 255) ? 255 : int'(cnt0) + n_extra));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pipe_sel", 128'(pipe_sel), 128'd1);
        chk("R1 sample_ctl", 128'(sample_ctl), 128'd1);
        chk("R1 insel_ctl", 128'(insel_ctl), 128'd1);
        chk("R1 chan_sel", chan_sel, 128'd0);
        chk("R1 adc_strobe", 128'(adc_strobe), 128'd0);
        chk("R1 done", 128'(done), 128'd0);
        chk("R1 reset_ctl", 128'(reset_ctl), 128'd0);
        chk("R1 dropped_cnt", 128'(dropped_cnt), 128'd0);
    endtask

    task automatic t_advance();
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            chk("R2 ring advance", 128'(pipe_sel), 128'(32'd1 << (i % 32)));
        end
    endtask

    task automatic t_readouts();
        repeat (3) @(negedge clk);
        run_read(5'd3, 0);
        wait_slot(2);
        run_read(5'd5, 0);
        wait_slot(17);
        run_read(5'd0, 0);
        wait_slot(31);
        run_read(5'd31, 0);
    endtask

    task automatic t_drop();
        wait_slot(9);
        run_read(5'd4, 3);
    endtask

    task automatic t_saturate();
        trigger = 1'b1;
        repeat (300) @(negedge clk);
        trigger = 1'b0;
        wait_sampling();
        chk("R8 dropped saturated", 128'(dropped_cnt), 128'd255);
        run_read(5'd1, 2);
    endtask

    task automatic t_beam();
        beam_xing = 1'b1;
        @(negedge clk);
        beam_xing = 1'b0;
        chk("R9 clear pulse", 128'(reset_ctl), 128'd1);
        @(negedge clk);
        chk("R9 clear pulse ends", 128'(reset_ctl), 128'd0);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        beam_xing = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 no clear in readout", 128'(reset_ctl), 128'd0);
        end
        beam_xing = 1'b0;
        wait_sampling();
    endtask

    task automatic t_cal();
        cal_enable = 1'b1;
        cal_slot = 5'd5;
        do_reset();
        chk("R10 cal high after reset", 128'(cal_ctl), 128'd1);
        wait_slot(5);
        chk("R10 cal high at slot", 128'(cal_ctl), 128'd1);
        @(negedge clk);
        chk("R10 cal falls", 128'(cal_ctl), 128'd0);
        repeat (34) @(negedge clk);
        chk("R10 cal stays low", 128'(cal_ctl), 128'd0);
        run_read(5'd2, 0);
        chk("R10 cal re-armed at done", 128'(cal_ctl), 128'd1);
        cal_enable = 1'b0;
        @(negedge clk);
        chk("R10 cal disabled", 128'(cal_ctl), 128'd0);
    endtask

    task automatic t_bleed();
        bleed_en = 1'b1;
        @(negedge clk);
        chk("R11 bleed high", 128'(bleed_ctl), 128'd1);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk("R11 bleed high in readout", 128'(bleed_ctl), 128'd1);
        bleed_en = 1'b0;
        @(negedge clk);
        chk("R11 bleed low in readout", 128'(bleed_ctl), 128'd0);
        wait_sampling();
    endtask

    initial begin
        t_reset();
        t_advance();
        t_readouts();
        t_drop();
        t_beam();
        t_saturate();
        t_bleed();
        t_cal();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule